// File: doc/BRIEF.md
# Clock Ratio Speed Mode Detector

This block runs on an audio converter's master clock. It counts how many master-clock cycles fall between successive rising edges of the frame clock (LRCK). It then maps that count to one of three sampling-speed classes for the playback (DAC) path: normal, double or quad. A small filter sits between the measurement and the output. It accepts a new class only after several frames in a row agree, so a glitch or a clock switch cannot make the speed code chatter.

A control input chooses where the DAC speed code comes from. It can come from the detector, or it can be passed straight through from a 2-bit field held by software. The record (ADC) path speed output is tied to normal speed. A lock flag reports whether the detector currently trusts the frame clock.

Top module: `clk_ratio_speed_detect`

## Requirements
- R1: With `auto_en`=1, `dac_speed` comes from the measured ratio and the value of `manual_speed` has no effect on it.
- R2: A frame of 512 or 768 master clocks selects normal speed, code 2'b00.
- R3: A frame of 256 or 384 master clocks selects double speed, code 2'b01.
- R4: A frame of 128 or 192 master clocks selects quad speed, code 2'b10.
- R5: A count is a supported ratio only if it lies within ±2 cycles of 128, 192, 256, 384, 512 or 768. For example, 130 and 766 are accepted, while 125, 300 and 515 never produce lock.
- R6: `ratio_lock` rises, and the detected mode is updated, only when 4 consecutive measured frames match the same ratio. Three matching frames are not enough.
- R7: An unsupported count, or a supported count that differs from the running ratio, clears `ratio_lock` and leaves the detected mode unchanged.
- R8: The period counter saturates at 1023 master clocks. When no LRCK rising edge arrives before saturation, `ratio_lock` clears and the detected mode is kept.
- R9: With `auto_en`=0, `dac_speed` equals `manual_speed` for all four codes, including 2'b11.
- R10: `adc_speed` is always 2'b00, whatever the other inputs are.
- R11: Synchronous active-high `rst` clears `ratio_lock` and returns the detected mode to 2'b00.
- R12: With `auto_en`=1, `dac_speed` is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame clock, asynchronous to `clk` |
| auto_en | input | 1 | 1: DAC speed from detector; 0: from `manual_speed` |
| manual_speed | input | 2 | Software speed field |
| dac_speed | output | 2 | DAC path speed code (00 normal, 01 double, 10 quad) |
| adc_speed | output | 2 | ADC path speed code, always normal |
| ratio_lock | output | 1 | Detector has seen enough agreeing frames |

## Verification
A rising edge on `lrck` passes through two synchroniser flops, so the edge pulse appears after the second clock edge. The lock and mode registers update on the third clock edge. The bench therefore holds `lrck` high for 8 cycles after each rise it makes, and only then samples the outputs, on the falling clock edge. The `auto_en` and `manual_speed` paths to `dac_speed` are combinational, so they are checked one cycle after the bench changes them. The timeout is checked in two places: 890 cycles after the last edge, before the counter saturates, and again 200 cycles later, after it has saturated.

// File: rtl/spdmode_pkg.sv
package spdmode_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_RSVD   = 2'b11
   } speed_e;

   // Six accepted ratios, two per speed class, ordered fastest first
   localparam int unsigned NUM_RATIOS = 6;
   localparam int unsigned IDX_W      = 3;

   function automatic int unsigned ratio_of(input int unsigned base, input int unsigned i);
      case (i)
         0:       return base;
         1:       return (base * 3) / 2;
         2:       return base * 2;
         3:       return base * 3;
         4:       return base * 4;
         default: return base * 6;
      endcase
   endfunction

   function automatic speed_e mode_of(input logic [IDX_W-1:0] i);
      if (i < 3'd2)      return SPD_QUAD;
      else if (i < 3'd4) return SPD_DOUBLE;
      else               return SPD_NORMAL;
   endfunction

endpackage

// File: rtl/lrck_sync.sv
module lrck_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic lrck_async,
   output logic rise
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("lrck_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Stages 0..SYNC_STAGES-1 synchronise; the last one keeps history for the edge
   logic [SYNC_STAGES:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[SYNC_STAGES-1:0], lrck_async};
   end

   assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

   // An edge pulse can never last two cycles
   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise); // R6

endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise,
   output logic             frame_stb,
   output logic [CNT_W-1:0] frame_len,
   output logic             saturated
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic             armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (rise) begin
         cnt   <= CNT_ONE;
         armed <= 1'b1;
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + CNT_ONE;
      end
   end

   // First edge after reset only arms; later edges close a complete frame
   assign frame_stb = rise & armed;
   assign frame_len = cnt;
   assign saturated = (cnt == CNT_MAX);

   AST_CNT_STICKS: assert property (@(posedge clk) disable iff (rst)
      (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX)); // R8

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
      rise |=> (cnt == CNT_ONE)); // R5

endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
   import spdmode_pkg::*;
#(
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned BASE_RATIO = 128,
   parameter int unsigned TOL        = 2
) (
   input  logic [CNT_W-1:0] frame_len,
   output logic             supported,
   output logic [IDX_W-1:0] ratio_idx,
   output speed_e           frame_mode
);
   // Closest neighbouring ratios are BASE/2 apart; windows must not touch
   generate
      if (2 * TOL >= BASE_RATIO / 2) begin : g_bad_tol
         $error("ratio_classifier: TOL too wide for BASE_RATIO");
      end
   endgenerate

   logic [NUM_RATIOS-1:0] hit;

   genvar g;
   generate
      for (g = 0; g < NUM_RATIOS; g++) begin : g_win
         localparam int unsigned CENTRE = ratio_of(BASE_RATIO, g);
         assign hit[g] = (32'(frame_len) + TOL >= CENTRE) &&
                         (32'(frame_len) <= CENTRE + TOL);
      end
   endgenerate

   always_comb begin
      ratio_idx = '0;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (hit[i]) ratio_idx = IDX_W'(i);
      end
   end

   assign supported  = |hit;
   assign frame_mode = mode_of(ratio_idx);

endmodule

// File: rtl/lock_filter.sv
module lock_filter
   import spdmode_pkg::*;
#(
   parameter int unsigned LOCK_FRAMES = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_stb,
   input  logic             supported,
   input  logic [IDX_W-1:0] ratio_idx,
   input  speed_e           frame_mode,
   input  logic             saturated,
   output logic             locked,
   output speed_e           det_mode
);
   generate
      if (LOCK_FRAMES < 2) begin : g_bad_frames
         $error("lock_filter: LOCK_FRAMES must be at least 2");
      end
   endgenerate

   localparam int unsigned RUN_W = $clog2(LOCK_FRAMES + 1);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_FRAMES);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_FRAMES - 1);

   logic [RUN_W-1:0] run;
   logic [IDX_W-1:0] prev_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         run      <= '0;
         prev_idx <= '0;
         locked   <= 1'b0;
         det_mode <= SPD_NORMAL;
      end else if (saturated) begin
         run    <= '0;
         locked <= 1'b0;
      end else if (frame_stb) begin
         if (!supported) begin
            run    <= '0;
            locked <= 1'b0;
         end else if (run != '0 && ratio_idx == prev_idx) begin
            if (run != RUN_FULL) run <= run + RUN_W'(1);
            if (run >= RUN_LAST) begin
               locked   <= 1'b1;
               det_mode <= frame_mode;
            end
         end else begin
            prev_idx <= ratio_idx;
            run      <= RUN_W'(1);
            locked   <= 1'b0;
         end
      end
   end

   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
      locked |-> (run == RUN_FULL)); // R6

   AST_MODE_MOVES_LOCKED: assert property (@(posedge clk) disable iff (rst)
      !$stable(det_mode) |-> locked); // R7

   AST_BAD_FRAME_UNLOCK: assert property (@(posedge clk) disable iff (rst)
      (frame_stb && !supported && !saturated) |=> !locked); // R7

   AST_TIMEOUT_UNLOCK: assert property (@(posedge clk) disable iff (rst)
      saturated |=> !locked); // R8

endmodule

// File: rtl/clk_ratio_speed_detect.sv
module clk_ratio_speed_detect
   import spdmode_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned BASE_RATIO  = 128,
   parameter int unsigned TOL         = 2,
   parameter int unsigned LOCK_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       lrck,
   input  logic       auto_en,
   input  logic [1:0] manual_speed,
   output logic [1:0] dac_speed,
   output logic [1:0] adc_speed,
   output logic       ratio_lock
);
   localparam int unsigned TOP_RATIO = ratio_of(BASE_RATIO, NUM_RATIOS - 1);

   generate
      if (TOP_RATIO + TOL >= (2 ** CNT_W) - 1) begin : g_bad_width
         $error("clk_ratio_speed_detect: CNT_W too small for largest ratio");
      end
   endgenerate

   logic             rise;
   logic             frame_stb;
   logic [CNT_W-1:0] frame_len;
   logic             saturated;
   logic             supported;
   logic [IDX_W-1:0] ratio_idx;
   speed_e           frame_mode;
   speed_e           det_mode;

   lrck_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .lrck_async (lrck),
      .rise       (rise)
   );

   period_counter #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst       (rst),
      .rise      (rise),
      .frame_stb (frame_stb),
      .frame_len (frame_len),
      .saturated (saturated)
   );

   ratio_classifier #(
      .CNT_W      (CNT_W),
      .BASE_RATIO (BASE_RATIO),
      .TOL        (TOL)
   ) u_class (
      .frame_len  (frame_len),
      .supported  (supported),
      .ratio_idx  (ratio_idx),
      .frame_mode (frame_mode)
   );

   lock_filter #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
      .clk        (clk),
      .rst        (rst),
      .frame_stb  (frame_stb),
      .supported  (supported),
      .ratio_idx  (ratio_idx),
      .frame_mode (frame_mode),
      .saturated  (saturated),
      .locked     (ratio_lock),
      .det_mode   (det_mode)
   );

   assign dac_speed = auto_en ? det_mode : manual_speed;
   assign adc_speed = SPD_NORMAL;

   AST_AUTO_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
      auto_en |-> (dac_speed != SPD_RSVD)); // R12

   AST_AUTO_IGNORES_FIELD: assert property (@(posedge clk) disable iff (rst)
      (auto_en && $past(auto_en) && $stable(det_mode)) |-> $stable(dac_speed)); // R1

endmodule

// File: tb/clk_ratio_speed_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_speed_detect_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       lrck = 1'b0;
   logic       auto_en = 1'b1;
   logic [1:0] manual_speed = 2'b00;
   logic [1:0] dac_speed;
   logic [1:0] adc_speed;
   logic       ratio_lock;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_ratio_speed_detect u_dut (
      .clk          (clk),
      .rst          (rst),
      .lrck         (lrck),
      .auto_en      (auto_en),
      .manual_speed (manual_speed),
      .dac_speed    (dac_speed),
      .adc_speed    (adc_speed),
      .ratio_lock   (ratio_lock)
   );

   // {period[9:0], auto, manual[1:0], expected dac[1:0], expected lock}
   localparam logic [15:0] VEC [0:11] = '{
      {10'd128, 1'b1, 2'b00, 2'b10, 1'b1},  // R4
      {10'd192, 1'b1, 2'b11, 2'b10, 1'b1},  // R4 R1
      {10'd256, 1'b1, 2'b00, 2'b01, 1'b1},  // R3
      {10'd384, 1'b1, 2'b10, 2'b01, 1'b1},  // R3 R1
      {10'd512, 1'b1, 2'b00, 2'b00, 1'b1},  // R2
      {10'd768, 1'b1, 2'b01, 2'b00, 1'b1},  // R2 R1
      {10'd130, 1'b1, 2'b00, 2'b10, 1'b1},  // R5 edge of window
      {10'd766, 1'b1, 2'b00, 2'b00, 1'b1},  // R5 edge of window
      {10'd515, 1'b1, 2'b00, 2'b00, 1'b0},  // R5 just outside
      {10'd125, 1'b1, 2'b00, 2'b00, 1'b0},  // R5 just outside
      {10'd300, 1'b1, 2'b11, 2'b00, 1'b0},  // R5 R12
      {10'd256, 1'b0, 2'b10, 2'b10, 1'b1}   // R9 manual while locked
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1; lrck = 1'b0;
      cyc(4);
      rst = 1'b0;
   endtask

   task automatic run(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         lrck = 1'b1; cyc(p / 2);
         lrck = 1'b0; cyc(p - p / 2);
      end
   endtask

   task automatic rise_wait();
      lrck = 1'b1; cyc(8);
   endtask

   task automatic rest(input int p);
      cyc(p / 2 - 8);
      lrck = 1'b0; cyc(p - p / 2);
   endtask

   task automatic chk(input string req, input logic [1:0] exp_dac, input logic exp_lock);
      n_chk++;
      if (dac_speed !== exp_dac || ratio_lock !== exp_lock) begin
         n_bad++;
         $display("FAIL %s: dac=%b lock=%b expected dac=%b lock=%b",
                  req, dac_speed, ratio_lock, exp_dac, exp_lock);
      end
      n_chk++;
      if (adc_speed !== 2'b00) begin
         n_bad++;
         $display("FAIL R10: adc=%b expected adc=00", adc_speed);
      end
   endtask

   initial begin
      cyc(3);
      chk("R11 reset state", 2'b00, 1'b0);
      do_reset();

      // Vector table
      for (int v = 0; v < 12; v++) begin
         do_reset();
         auto_en      = VEC[v][5];
         manual_speed = VEC[v][4:3];
         run(int'(VEC[v][15:6]), 5);
         rise_wait();
         chk($sformatf("R1-vector %0d period %0d", v, VEC[v][15:6]), VEC[v][2:1], VEC[v][0]);
         rest(int'(VEC[v][15:6]));
      end
      auto_en = 1'b1; manual_speed = 2'b00;

      // R6: three matching frames are not enough, the fourth locks
      do_reset();
      run(256, 3);
      rise_wait();
      chk("R6 three frames", 2'b00, 1'b0);
      rest(256);
      rise_wait();
      chk("R6 four frames", 2'b01, 1'b1);
      rest(256);

      // R7: unsupported frame drops lock, quad mode kept
      do_reset();
      run(128, 5);
      rise_wait();
      chk("R4 lock quad", 2'b10, 1'b1);
      rest(128);
      run(700, 1);
      rise_wait();
      chk("R7 unsupported keeps mode", 2'b10, 1'b0);

      // R9 all manual codes, R1/R12 auto ignores field
      auto_en = 1'b0; manual_speed = 2'b01; cyc(1);
      chk("R9 manual 01", 2'b01, 1'b0);
      manual_speed = 2'b11; cyc(1);
      chk("R9 manual 11", 2'b11, 1'b0);
      manual_speed = 2'b00; cyc(1);
      chk("R9 manual 00", 2'b00, 1'b0);
      auto_en = 1'b1; manual_speed = 2'b11; cyc(1);
      chk("R12 auto ignores 11", 2'b10, 1'b0);
      manual_speed = 2'b00;
      rest(700);

      // R7: a different supported ratio drops lock, then relocks
      do_reset();
      run(512, 5);
      rise_wait();
      chk("R2 lock normal 512", 2'b00, 1'b1);
      rest(512);
      run(768, 1);
      rise_wait();
      chk("R7 ratio mismatch", 2'b00, 1'b0);
      rest(768);
      run(768, 3);
      rise_wait();
      chk("R7 relock 768", 2'b00, 1'b1);
      rest(768);

      // R8: saturation with no edge drops lock, mode kept
      do_reset();
      run(256, 5);
      rise_wait();
      chk("R3 lock double", 2'b01, 1'b1);
      lrck = 1'b0;
      cyc(890);
      chk("R8 before saturation", 2'b01, 1'b1);
      cyc(200);
      chk("R8 after saturation", 2'b01, 1'b0);

      // R11: reset from a locked quad state
      run(192, 6);
      rise_wait();
      chk("R4 lock 192", 2'b10, 1'b1);
      rst = 1'b1; cyc(2);
      chk("R11 reset clears", 2'b00, 1'b0);
      rst = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule